// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block moves the bits of a 32-bit word by a variable count in one of eight ways: four shifts (two left, one logical right, one arithmetic right), two plain rotates, and two rotates that pass the bits through the carry flag. It takes the word, the count, an operation code and the current carry and overflow flags. One clock later it returns the new word with the updated carry and overflow flags. The caller picks where the count comes from; the block only sees the count value.

Each operation is a single pass through a logarithmic barrel network, so any count takes the same single cycle. A count whose low five bits are zero is a no-op that returns the word and both flags unchanged. The rotates through carry treat the flag as a 33rd bit above the word.

Top module: `sr_unit`

## Requirements
- R1: A request with `in_valid` high is answered on the next clock edge: `out_valid` is high for exactly that cycle and `res_data`, `res_cf`, `res_of` hold its result. In a cycle after an edge where `in_valid` was low, `out_valid` is low.
- R2: Only bits [4:0] of `count` are used. When they are zero, the request returns `src_data`, `cf_in` and `of_in` unchanged for every opcode.
- R3: Opcodes 0 and 2 (logical and arithmetic shift left) behave identically. Zeros enter at bit 0, and `res_cf` is the last bit moved out of bit 31, i.e. `src_data[32-n]` for masked count n.
- R4: Opcode 1 (logical shift right) fills bit 31 downward with zeros, and `res_cf` is `src_data[n-1]`.
- R5: Opcode 3 (arithmetic shift right) fills from the top with copies of `src_data[31]`, so bit 31 keeps its value, and `res_cf` is `src_data[n-1]`.
- R6: For the four shift opcodes (0 to 3), `res_of` equals `of_in`.
- R7: Opcode 4 rotates left over the 32 data bits only, and `res_cf` equals bit 0 of the new word.
- R8: Opcode 5 rotates right over the 32 data bits only, and `res_cf` equals bit 31 of the new word.
- R9: Opcodes 6 (left) and 7 (right) rotate the 33-bit value {`cf_in`, `src_data`}, with the carry above bit 31, by the masked count modulo 33. `res_cf` is the bit that lands in the carry position.
- R10: For opcodes 4 and 6 with masked count 1, `res_of` is bit 31 of the new word XOR the new carry. For every other rotate case, `res_of` equals `of_in`.
- R11: A synchronous active-high `rst` clears `out_valid`, `res_data`, `res_cf` and `res_of` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code (0 to 7, see requirements) |
| src_data | input | 32 | Word to shift or rotate |
| count | input | 8 | Count value; only bits [4:0] are used |
| cf_in | input | 1 | Current carry flag |
| of_in | input | 1 | Current overflow flag |
| out_valid | output | 1 | Result present this cycle |
| res_data | output | 32 | Shifted or rotated word |
| res_cf | output | 1 | New carry flag |
| res_of | output | 1 | New overflow flag |

## Verification
The assertions assume that `op`, `src_data`, `count` and the flag inputs are known whenever `in_valid` is high. They also assume that reset has been applied before the first request, since they compare each result with the inputs sampled one edge earlier. The stimulus changes the inputs only on the falling clock edge and holds them through the following rising edge. Requests start only after reset has been released. Each request is separated by an idle cycle, so the previous-cycle relations the assertions use always refer to the request being answered.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [2:0] {
        SR_SHL  = 3'd0,
        SR_SHR  = 3'd1,
        SR_SAL  = 3'd2,
        SR_SAR  = 3'd3,
        SR_ROL  = 3'd4,
        SR_ROR  = 3'd5,
        SR_RCL  = 3'd6,
        SR_RCR  = 3'd7
    } sr_op_e;

    typedef struct packed {
        logic cf;
        logic of;
    } sr_flags_t;

    typedef enum logic [1:0] {
        SR_CLASS_SHIFT = 2'd0,
        SR_CLASS_ROT   = 2'd1,
        SR_CLASS_RC    = 2'd2
    } sr_class_e;

    function automatic sr_class_e sr_class(input sr_op_e o);
        case (o)
            SR_ROL, SR_ROR: return SR_CLASS_ROT;
            SR_RCL, SR_RCR: return SR_CLASS_RC;
            default:        return SR_CLASS_SHIFT;
        endcase
    endfunction

    function automatic logic sr_is_left(input sr_op_e o);
        return (o == SR_SHL) || (o == SR_SAL) || (o == SR_ROL) || (o == SR_RCL);
    endfunction

    function automatic logic sr_left_rotate(input sr_op_e o);
        return (o == SR_ROL) || (o == SR_RCL);
    endfunction

endpackage

// File: rtl/sr_count_prep.sv
module sr_count_prep #(
    parameter int W  = 32,
    parameter int CW = 8,
    localparam int AW = $clog2(W)
) (
    input  logic [CW-1:0] count,
    input  logic          left,
    output logic [AW-1:0] amt,
    output logic          amt_zero,
    output logic [AW-1:0] rot_amt,
    output logic [AW:0]   rc_amt
);
    logic [31:0] m32;
    logic [31:0] rc_left;
    logic [31:0] rot_eff;
    logic [31:0] rc_eff;

    always_comb begin
        amt      = count[AW-1:0];
        amt_zero = (amt == '0);
        m32      = 32'(amt);
        // through-carry rotation spans W+1 positions
        rc_left  = m32 % (W + 1);
        // right rotations are mapped onto a left rotator
        rot_eff  = left ? m32     : ((W - m32) % W);
        rc_eff   = left ? rc_left : ((W + 1 - rc_left) % (W + 1));
        rot_amt  = rot_eff[AW-1:0];
        rc_amt   = rc_eff[AW:0];
    end
endmodule

// File: rtl/sr_rotl.sv
module sr_rotl #(
    parameter int N  = 32,
    parameter int AW = 5
) (
    input  logic [N-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [N-1:0]  dout
);
    logic [N-1:0] stage [AW+1];

    assign stage[0] = din;

    for (genvar i = 0; i < AW; i++) begin : g_stage
        localparam int R = (1 << i) % N;
        if (R == 0) begin : g_pass
            assign stage[i+1] = stage[i];
        end else begin : g_rot
            assign stage[i+1] = amt[i] ? {stage[i][N-1-R:0], stage[i][N-1:N-R]}
                                       : stage[i];
        end
    end

    assign dout = stage[AW];
endmodule

// File: rtl/sr_shift.sv
module sr_shift #(
    parameter int N  = 33,
    parameter int AW = 5
) (
    input  logic [N-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          left,
    input  logic          fill,
    output logic [N-1:0]  dout
);
    logic [N-1:0] stage [AW+1];

    assign stage[0] = din;

    for (genvar i = 0; i < AW; i++) begin : g_stage
        localparam int S = 1 << i;
        logic [N-1:0] top_mask;
        logic [N-1:0] moved;
        assign top_mask = ~({N{1'b1}} >> S);
        assign moved    = left ? (stage[i] << S)
                               : ((stage[i] >> S) | (fill ? top_mask : '0));
        assign stage[i+1] = amt[i] ? moved : stage[i];
    end

    assign dout = stage[AW];
endmodule

// File: rtl/sr_unit.sv
module sr_unit
    import sr_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    op,
    input  logic [W-1:0]  src_data,
    input  logic [CW-1:0] count,
    input  logic          cf_in,
    input  logic          of_in,
    output logic          out_valid,
    output logic [W-1:0]  res_data,
    output logic          res_cf,
    output logic          res_of
);
    localparam int AW = $clog2(W);

    sr_op_e        op_e;
    logic          left;
    logic [AW-1:0] amt;
    logic          amt_zero;
    logic [AW-1:0] rot_amt;
    logic [AW:0]   rc_amt;

    assign op_e = sr_op_e'(op);
    assign left = sr_is_left(op_e);

    sr_count_prep #(.W(W), .CW(CW)) u_cnt (
        .count    (count),
        .left     (left),
        .amt      (amt),
        .amt_zero (amt_zero),
        .rot_amt  (rot_amt),
        .rc_amt   (rc_amt)
    );

    // shifts: one spare bit catches the last bit moved out
    logic [W:0] sh_in, sh_out;
    logic       sh_fill;
    assign sh_in   = left ? {1'b0, src_data} : {src_data, 1'b0};
    assign sh_fill = (op_e == SR_SAR) & src_data[W-1];

    sr_shift #(.N(W+1), .AW(AW)) u_shift (
        .din  (sh_in),
        .amt  (amt),
        .left (left),
        .fill (sh_fill),
        .dout (sh_out)
    );

    logic [W-1:0] rot_out;
    sr_rotl #(.N(W), .AW(AW)) u_rot (
        .din  (src_data),
        .amt  (rot_amt),
        .dout (rot_out)
    );

    logic [W:0] rc_out;
    sr_rotl #(.N(W+1), .AW(AW+1)) u_rc (
        .din  ({cf_in, src_data}),
        .amt  (rc_amt),
        .dout (rc_out)
    );

    logic [W-1:0] nxt_data;
    sr_flags_t    nxt_fl;

    always_comb begin
        nxt_data = src_data;
        nxt_fl   = '{cf: cf_in, of: of_in};
        if (!amt_zero) begin
            case (sr_class(op_e))
                SR_CLASS_ROT: begin
                    nxt_data  = rot_out;
                    nxt_fl.cf = left ? rot_out[0] : rot_out[W-1];
                end
                SR_CLASS_RC: begin
                    nxt_data  = rc_out[W-1:0];
                    nxt_fl.cf = rc_out[W];
                end
                default: begin
                    nxt_data  = left ? sh_out[W-1:0] : sh_out[W:1];
                    nxt_fl.cf = left ? sh_out[W] : sh_out[0];
                end
            endcase
            if (sr_left_rotate(op_e) && (amt == AW'(1)))
                nxt_fl.of = nxt_data[W-1] ^ nxt_fl.cf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_data  <= '0;
            res_cf    <= 1'b0;
            res_of    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_data <= nxt_data;
                res_cf   <= nxt_fl.cf;
                res_of   <= nxt_fl.of;
            end
        end
    end
endmodule

// File: rtl/sr_unit_chk.sv
module sr_unit_chk #(
    parameter int W  = 32,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [2:0]    op,
    input logic [W-1:0]  src_data,
    input logic [CW-1:0] count,
    input logic          cf_in,
    input logic          of_in,
    input logic          out_valid,
    input logic [W-1:0]  res_data,
    input logic          res_cf,
    input logic          res_of
);
    localparam int AW = $clog2(W);

    logic [AW-1:0] m;
    assign m = count[AW-1:0];

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r2_zero_count: assert property (@(posedge clk) disable iff (rst)
        (in_valid && m == '0) |=>
        (res_data == $past(src_data) && res_cf == $past(cf_in) && res_of == $past(of_in)));

    a_r5_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd3) |=> res_data[W-1] == $past(src_data[W-1]));

    a_r6_shift_of: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[2] == 1'b0) |=> res_of == $past(of_in));

    a_r7_rol_carry: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd4 && m != '0) |=> res_cf == res_data[0]);

    a_r8_ror_carry: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd5 && m != '0) |=> res_cf == res_data[W-1]);

    a_r10_left_of: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 3'd4 || op == 3'd6) && m == AW'(1)) |=>
        res_of == (res_data[W-1] ^ res_cf));

    a_r10_right_of: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 3'd5 || op == 3'd7)) |=> res_of == $past(of_in));

    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && res_data == '0 && !res_cf && !res_of));
endmodule

bind sr_unit sr_unit_chk #(.W(W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .src_data  (src_data),
    .count     (count),
    .cf_in     (cf_in),
    .of_in     (of_in),
    .out_valid (out_valid),
    .res_data  (res_data),
    .res_cf    (res_cf),
    .res_of    (res_of)
);

// File: tb/sim_sr_unit.sv
`timescale 1ns/1ps
module sim_sr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] src_data = '0;
    logic [7:0]  count = '0;
    logic        cf_in = 1'b0;
    logic        of_in = 1'b0;
    logic        out_valid;
    logic [31:0] res_data;
    logic        res_cf;
    logic        res_of;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sr_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .src_data(src_data), .count(count), .cf_in(cf_in), .of_in(of_in),
        .out_valid(out_valid), .res_data(res_data), .res_cf(res_cf), .res_of(res_of)
    );

    // Behavioural reference: moves one bit per step
    task automatic ref_op(input logic [2:0] o, input logic [31:0] d, input logic [7:0] c,
                          input logic cf, input logic of,
                          output logic [31:0] r, output logic rcf, output logic rof);
        int n;
        n = c % 32;
        r = d; rcf = cf; rof = of;
        for (int k = 0; k < n; k++) begin
            case (o)
                3'd0, 3'd2: begin rcf = r[31]; r = r << 1; end
                3'd1:       begin rcf = r[0];  r = r >> 1; end
                3'd3:       begin rcf = r[0];  r = {r[31], r[31:1]}; end
                3'd4:       begin r = {r[30:0], r[31]}; rcf = r[0]; end
                3'd5:       begin r = {r[0], r[31:1]}; rcf = r[31]; end
                3'd6:       {rcf, r} = {r, rcf};
                default:    {r, rcf} = {rcf, r};
            endcase
        end
        if (n == 1 && (o == 3'd4 || o == 3'd6)) rof = r[31] ^ rcf;
    endtask

    function automatic string tag_of(input logic [2:0] o, input logic [7:0] c);
        if (c[4:0] == 5'd0) return "R2";
        case (o)
            3'd0, 3'd2: return "R3";
            3'd1:       return "R4";
            3'd3:       return "R5";
            3'd4:       return "R7";
            3'd5:       return "R8";
            default:    return "R9";
        endcase
    endfunction

    task automatic check1(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] o, input logic [31:0] d, input logic [7:0] c,
                       input logic cf, input logic of);
        logic [31:0] er;
        logic ecf, eof;
        string t;
        ref_op(o, d, c, cf, of, er, ecf, eof);
        t = tag_of(o, c);
        @(negedge clk);
        op = o; src_data = d; count = c; cf_in = cf; of_in = of; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check1("R1", "out_valid", 32'(out_valid), 32'd1);
        check1(t, "res_data", res_data, er);
        check1(t, "res_cf", 32'(res_cf), 32'(ecf));
        if (c[4:0] == 5'd0)      check1("R2", "res_of", 32'(res_of), 32'(eof));
        else if (o[2] == 1'b0)   check1("R6", "res_of", 32'(res_of), 32'(eof));
        else                     check1("R10", "res_of", 32'(res_of), 32'(eof));
        @(negedge clk);
        check1("R1", "idle out_valid", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check1("R11", "out_valid", 32'(out_valid), 32'd0);
        check1("R11", "res_data", res_data, 32'd0);
        check1("R11", "flags", 32'({res_cf, res_of}), 32'd0);
        rst = 1'b0;

        // directed corners
        for (int o = 0; o < 8; o++) begin
            run(3'(o), 32'h8000_0001, 8'd0,   1'b1, 1'b1);
            run(3'(o), 32'h8000_0001, 8'd32,  1'b0, 1'b1);
            run(3'(o), 32'hC000_0003, 8'd1,   1'b0, 1'b0);
            run(3'(o), 32'h4000_0002, 8'd1,   1'b1, 1'b1);
            run(3'(o), 32'hA5A5_5A5A, 8'd31,  1'b1, 1'b0);
            run(3'(o), 32'h8765_4321, 8'd33,  1'b0, 1'b1);
            run(3'(o), 32'hF0F0_0F0F, 8'd255, 1'b1, 1'b0);
            run(3'(o), 32'h7FFF_FFFE, 8'd16,  1'b1, 1'b1);
        end
        // random
        for (int i = 0; i < 1500; i++) begin
            run(3'($urandom_range(7)), $urandom, 8'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule